// File: doc/BRIEF.md
# Multicycle Processor Core

A 32-bit processor core that spreads each instruction across several clock cycles. It reuses one memory port and one arithmetic unit from cycle to cycle. A small finite-state sequencer walks every instruction through fetch and decode, then through a class-specific tail. The supported classes are register arithmetic/logic, word load, word store and branch-if-equal.

Values that must survive from one step to the next are parked in hidden registers: the instruction word, the memory data word, the two register operands and the arithmetic result. The program counter, the register file and memory are the only state a program can see.

The core drives one address bus that serves both instruction fetch and data access. It takes the read word back in the same cycle. For observation it exposes the program counter, the memory write strobe with its address and data, and the register-file write strobe with its address and data.

Top module: `mcyc_core`

## Requirements
- R1: While reset is low, the program counter reads 0, no memory or register write strobe is raised, and the address bus carries the program counter. The first cycle after reset is a fetch, and every register reads zero.
- R2: In each fetch cycle the address bus carries the program counter, and the program counter becomes PC+4 at the end of that cycle. At all other times the program counter changes only in a taken branch step, and it always stays a multiple of 4.
- R3: The instruction word is captured only in fetch cycles and holds unchanged in every other cycle.
- R4: Opcode field bits [31:26] select the class: 0x00 register op, 0x23 load, 0x2B store, 0x04 branch-if-equal. The cycle counts are 3 for a branch, 4 for a register op, 4 for a store and 5 for a load. Every fetch is followed by decode. Any other opcode takes 2 cycles (fetch and decode) and changes nothing except the program counter.
- R5: A register op reads rs at bits [25:21] and rt at bits [20:16], and writes rd at bits [15:11] in its 4th cycle. The function field, bits [5:0], selects the operation: 0x20 add, 0x22 subtract (rs-rt), 0x24 AND, 0x25 OR, 0x2A signed less-than (1 or 0). Any other function code adds.
- R6: A load reads the word at rs plus the sign-extended bits [15:0], and writes it to register rt in its 5th cycle.
- R7: A store raises the memory write strobe for exactly its 4th cycle. The address is rs plus the sign-extended bits [15:0] and the data is register rt. A fetch follows at once.
- R8: A branch compares rs and rt by subtraction in its 3rd cycle. If they are equal, the program counter becomes (branch address + 4) + (sign-extended bits [15:0] shifted left by 2). Otherwise it stays at branch address + 4.
- R9: A write aimed at register 0 raises no register write strobe, and register 0 always reads zero.
- R10: The memory write strobe is raised only in a store's write step, never in fetch or decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 32 | Word read at mem_addr, valid in the same cycle |
| mem_addr | output | 32 | Shared instruction/data byte address |
| mem_we | output | 1 | Memory write strobe, one cycle per store |
| mem_wdata | output | 32 | Store data |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | 32 | Register-file write data |

## Verification
The properties assume that the memory answers combinationally: mem_rdata holds the word at mem_addr within the same cycle. They also assume that reset is held for at least one clock edge. The program-counter alignment property further assumes that branch offsets only move in whole words, which holds for any encoding.

The bench keeps within these assumptions. Its memory model is read straight from the address bus and written on the rising edge. Every load and store offset in the program is word aligned, and reset is driven at falling edges only.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int unsigned DW  = 32;
  localparam int unsigned RAW = 5;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXEC, S_RWB, S_ADDR, S_MRD, S_LWB, S_MWR, S_BRANCH
  } step_e;

  typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT} aluop_e;

  typedef enum logic [1:0] {BS_REG, BS_FOUR, BS_IMM, BS_IMM4} bsel_e;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic   ir_load;   // capture instruction word
    logic   pc_step;   // PC <= ALU result (fetch)
    logic   br_step;   // branch compare step
    logic   a_is_pc;   // ALU port A from PC
    bsel_e  bsel;      // ALU port B source
    aluop_e op;
    logic   addr_alu;  // address bus from ALU result register
    logic   mem_we;
    logic   rf_we;
    logic   dst_rd;    // write rd (else rt)
    logic   wb_mdr;    // write data from memory data register
  } ctl_t;

  function automatic logic [DW-1:0] sext16(input logic [15:0] v);
    return {{(DW-16){v[15]}}, v};
  endfunction

  function automatic aluop_e funct_to_op(input logic [5:0] fn);
    case (fn)
      FN_SUB:  return OP_SUB;
      FN_AND:  return OP_AND;
      FN_OR:   return OP_OR;
      FN_SLT:  return OP_SLT;
      default: return OP_ADD;
    endcase
  endfunction

  function automatic logic [DW-1:0] alu_calc(input aluop_e op,
                                              input logic [DW-1:0] a,
                                              input logic [DW-1:0] b);
    case (op)
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_SLT:  return ($signed(a) < $signed(b)) ? {{(DW-1){1'b0}}, 1'b1} : '0;
      default: return a + b;
    endcase
  endfunction

endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
  parameter int unsigned AW = 5,
  parameter int unsigned W  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  localparam int unsigned NREG = 1 << AW;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
(
  input  aluop_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);
  assign y    = alu_calc(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output step_e      step,
  output ctl_t       ctl
);
  step_e step_q, step_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= S_FETCH;
    else        step_q <= step_d;
  end

  always_comb begin
    ctl      = '0;
    ctl.bsel = BS_REG;
    ctl.op   = OP_ADD;
    step_d   = S_FETCH;
    case (step_q)
      S_FETCH: begin
        ctl.ir_load = 1'b1;
        ctl.pc_step = 1'b1;
        ctl.a_is_pc = 1'b1;
        ctl.bsel    = BS_FOUR;
        step_d      = S_DECODE;
      end
      S_DECODE: begin
        ctl.a_is_pc = 1'b1;
        ctl.bsel    = BS_IMM4;
        case (opcode)
          OPC_RTYPE:           step_d = S_EXEC;
          OPC_LOAD, OPC_STORE: step_d = S_ADDR;
          OPC_BEQ:             step_d = S_BRANCH;
          default:             step_d = S_FETCH;
        endcase
      end
      S_EXEC: begin
        ctl.op = funct_to_op(funct);
        step_d = S_RWB;
      end
      S_RWB: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rd = 1'b1;
      end
      S_ADDR: begin
        ctl.bsel = BS_IMM;
        step_d   = (opcode == OPC_LOAD) ? S_MRD : S_MWR;
      end
      S_MRD: begin
        ctl.addr_alu = 1'b1;
        step_d       = S_LWB;
      end
      S_LWB: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_mdr = 1'b1;
      end
      S_MWR: begin
        ctl.addr_alu = 1'b1;
        ctl.mem_we   = 1'b1;
      end
      S_BRANCH: begin
        ctl.br_step = 1'b1;
        ctl.op      = OP_SUB;
      end
      default: step_d = S_FETCH;
    endcase
  end

  assign step = step_q;
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  output logic [DW-1:0]  pc_o,
  output logic           rf_we_o,
  output logic [RAW-1:0] rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o
);
  logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [DW-1:0] rd1, rd2, alu_a, alu_b, alu_y;
  logic          alu_zero;
  step_e         step;
  ctl_t          ctl;

  logic [5:0]     f_opc, f_fn;
  logic [RAW-1:0] f_rs, f_rt, f_rd;
  logic [15:0]    f_imm;
  logic           unused_shamt;

  assign f_opc = ir_q[31:26];
  assign f_rs  = ir_q[25:21];
  assign f_rt  = ir_q[20:16];
  assign f_rd  = ir_q[15:11];
  assign f_imm = ir_q[15:0];
  assign f_fn  = ir_q[5:0];
  assign unused_shamt = ^ir_q[10:6];

  // named internal events for the checker
  logic ev_fetch, ev_decode, ev_branch, ev_taken;

  mcyc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(f_opc), .funct(f_fn),
    .step(step), .ctl(ctl)
  );

  logic [RAW-1:0] wb_addr;
  logic [DW-1:0]  wb_data;
  logic           wb_en;

  mcyc_regfile #(.AW(RAW), .W(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra1(f_rs), .ra2(f_rt), .rd1(rd1), .rd2(rd2),
    .we(wb_en), .wa(wb_addr), .wd(wb_data)
  );

  always_comb begin
    alu_a = ctl.a_is_pc ? pc_q : a_q;
    case (ctl.bsel)
      BS_FOUR: alu_b = 32'd4;
      BS_IMM:  alu_b = sext16(f_imm);
      BS_IMM4: alu_b = sext16(f_imm) << 2;
      default: alu_b = b_q;
    endcase
  end

  mcyc_alu u_alu (
    .op(ctl.op), .a(alu_a), .b(alu_b), .y(alu_y), .zero(alu_zero)
  );

  assign ev_fetch  = (step == S_FETCH);
  assign ev_decode = (step == S_DECODE);
  assign ev_branch = ctl.br_step;
  assign ev_taken  = ctl.br_step & alu_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (ctl.ir_load) ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      a_q      <= rd1;
      b_q      <= rd2;
      aluout_q <= alu_y;
      if (ctl.pc_step)   pc_q <= alu_y;
      else if (ev_taken) pc_q <= aluout_q;
    end
  end

  assign wb_addr = ctl.dst_rd ? f_rd : f_rt;
  assign wb_data = ctl.wb_mdr ? mdr_q : aluout_q;
  assign wb_en   = ctl.rf_we && (wb_addr != '0);

  assign mem_addr   = ctl.addr_alu ? aluout_q : pc_q;
  assign mem_we     = ctl.mem_we;
  assign mem_wdata  = b_q;
  assign pc_o       = pc_q;
  assign rf_we_o    = wb_en;
  assign rf_waddr_o = wb_addr;
  assign rf_wdata_o = wb_data;
endmodule

// File: rtl/mcyc_chk.sv
module mcyc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_fetch,
  input logic        ev_decode,
  input logic        ev_branch,
  input logic        ev_taken,
  input logic [31:0] pc,
  input logic [31:0] ir,
  input logic [31:0] aluout,
  input logic [31:0] mem_addr,
  input logic        mem_we
);
  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> pc == $past(pc) + 32'd4); // R2
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |-> mem_addr == pc); // R2
  AST_PC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_fetch && !ev_taken) |=> $stable(pc)); // R2
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00); // R2
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_fetch |=> $stable(ir)); // R3
  AST_DECODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> ev_decode); // R4
  AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_branch |=> ev_fetch); // R4
  AST_STORE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ev_fetch); // R7
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_taken |=> pc == $past(aluout)); // R8
  AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !ev_fetch && !ev_decode); // R10
endmodule

bind mcyc_core mcyc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_fetch(ev_fetch), .ev_decode(ev_decode),
  .ev_branch(ev_branch), .ev_taken(ev_taken), .pc(pc_q), .ir(ir_q),
  .aluout(aluout_q), .mem_addr(mem_addr), .mem_we(mem_we)
);

// File: tb/sim_mcyc_core.sv
`timescale 1ns/1ps
module sim_mcyc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_rdata, mem_addr, mem_wdata, pc_o, rf_wdata_o;
  logic        mem_we, rf_we_o;
  logic [4:0]  rf_waddr_o;

  int nchk = 0, nfail = 0, cyc = 0, nrf = 0, nmem = 0;

  always #2.5 clk = ~clk;

  mcyc_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .pc_o(pc_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
  );

  // memory model: combinational read, write on rising edge
  logic [31:0] mem [256];
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we_o) nrf++;
      if (mem_we)  nmem++;
    end
  end

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                        input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic goto(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic wrap_up;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // event kinds: 0 register write, 1 memory write, 2 PC value, 3 no register write
  // packing: {kind[73:72], cycle[71:64], addr[63:32], data[31:0]}
  localparam int NEV = 22;
  localparam logic [73:0] EVT [NEV] = '{
    {2'd2, 8'd1,  32'd0,     32'h4},
    {2'd0, 8'd4,  32'd1,     32'd7},
    {2'd0, 8'd9,  32'd2,     32'd5},
    {2'd0, 8'd13, 32'd3,     32'd12},
    {2'd0, 8'd17, 32'd4,     32'd2},
    {2'd0, 8'd21, 32'd5,     32'd5},
    {2'd0, 8'd25, 32'd6,     32'd7},
    {2'd0, 8'd29, 32'd7,     32'd1},
    {2'd0, 8'd33, 32'd8,     32'd0},
    {2'd3, 8'd37, 32'd0,     32'd0},
    {2'd1, 8'd41, 32'h108,   32'd12},
    {2'd2, 8'd42, 32'd0,     32'h28},
    {2'd2, 8'd45, 32'd0,     32'h2C},
    {2'd2, 8'd48, 32'd0,     32'h38},
    {2'd0, 8'd52, 32'd9,     32'd12},
    {2'd0, 8'd56, 32'd10,    32'hFFFF_FFF9},
    {2'd0, 8'd60, 32'd11,    32'd1},
    {2'd2, 8'd61, 32'd0,     32'h44},
    {2'd2, 8'd63, 32'd0,     32'h48},
    {2'd2, 8'd64, 32'd0,     32'h4C},
    {2'd2, 8'd66, 32'd0,     32'h48},
    {2'd3, 8'd67, 32'd0,     32'd0}
  };

  initial begin
    repeat (5000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual cycle %0d expected finish", cyc);
    wrap_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);    // load r1
    mem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);    // load r2
    mem[2]  = enc_r(6'h20, 5'd3, 5'd1, 5'd2);        // add
    mem[3]  = enc_r(6'h22, 5'd4, 5'd1, 5'd2);        // sub
    mem[4]  = enc_r(6'h24, 5'd5, 5'd1, 5'd2);        // and
    mem[5]  = enc_r(6'h25, 5'd6, 5'd1, 5'd2);        // or
    mem[6]  = enc_r(6'h2A, 5'd7, 5'd2, 5'd1);        // slt true
    mem[7]  = enc_r(6'h2A, 5'd8, 5'd1, 5'd2);        // slt false
    mem[8]  = enc_r(6'h20, 5'd0, 5'd1, 5'd2);        // write to r0
    mem[9]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);    // store r3
    mem[10] = enc_i(6'h04, 5'd1, 5'd2, 16'd5);       // branch not taken
    mem[11] = enc_i(6'h04, 5'd6, 5'd1, 16'd2);       // branch taken
    mem[12] = enc_r(6'h20, 5'd12, 5'd1, 5'd1);       // skipped
    mem[13] = enc_r(6'h20, 5'd12, 5'd1, 5'd1);       // skipped
    mem[14] = enc_i(6'h23, 5'd0, 5'd9, 16'h0108);    // load stored word
    mem[15] = enc_r(6'h22, 5'd10, 5'd0, 5'd1);       // 0 - 7
    mem[16] = enc_r(6'h2A, 5'd11, 5'd10, 5'd1);      // signed slt
    mem[17] = 32'hFC00_0000;                         // unsupported opcode
    mem[18] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);    // branch to self
    mem[64] = 32'd7;
    mem[65] = 32'd5;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pc_o == 32'h0, "R1", "pc in reset", pc_o, 32'h0);
    chk(!rf_we_o && !mem_we, "R1", "no strobes in reset", {30'd0, rf_we_o, mem_we}, 32'h0);
    chk(mem_addr == 32'h0, "R1", "address bus in reset", mem_addr, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NEV; i++) begin
      logic [73:0] e;
      string req;
      e = EVT[i];
      goto(int'(e[71:64]));
      case (e[73:72])
        2'd0: begin
          req = (e[63:32] == 32'd1 || e[63:32] == 32'd2 || e[63:32] == 32'd9) ? "R6" : "R5";
          chk(rf_we_o && rf_waddr_o == e[36:32] && rf_wdata_o == e[31:0], req,
              $sformatf("reg write cycle %0d r%0d (we=%0d addr=%0d)", cyc, e[36:32],
                        rf_we_o, rf_waddr_o), rf_wdata_o, e[31:0]);
        end
        2'd1: chk(mem_we && mem_addr == e[63:32] && mem_wdata == e[31:0], "R7",
                  $sformatf("store cycle %0d addr %h (we=%0d)", cyc, mem_addr, mem_we),
                  mem_wdata, e[31:0]);
        2'd2: chk(pc_o == e[31:0], "R2/R8", $sformatf("pc at cycle %0d", cyc),
                  pc_o, e[31:0]);
        default: chk(!rf_we_o, "R9", $sformatf("no reg write cycle %0d", cyc),
                     {31'd0, rf_we_o}, 32'h0);
      endcase
    end

    goto(70);
    chk(nrf == 11, "R9", "register write strobe count", nrf, 32'd11);
    chk(nmem == 1, "R10", "memory write strobe count", nmem, 32'd1);
    chk(mem[66] == 32'd12, "R7", "stored word in memory", mem[66], 32'd12);

    // R1: reset in mid-run, then restart from address 0
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(pc_o == 32'h0, "R1", "pc after mid-run reset", pc_o, 32'h0);
    chk(!rf_we_o && !mem_we, "R1", "no strobes after reset", {30'd0, rf_we_o, mem_we}, 32'h0);
    rst_n = 1'b1;
    goto(1);
    chk(pc_o == 32'h4, "R2", "pc after first fetch on restart", pc_o, 32'h4);
    goto(4);
    chk(rf_we_o && rf_waddr_o == 5'd1 && rf_wdata_o == 32'd7, "R4",
        "restart load lands in 5th cycle", rf_wdata_o, 32'd7);
    goto(13);
    chk(rf_we_o && rf_waddr_o == 5'd3 && rf_wdata_o == 32'd12, "R1",
        "registers restart from zero then reload", rf_wdata_o, 32'd12);

    wrap_up();
  end
endmodule